// File: doc/BRIEF.md
# Maze-Walking Agent Controller

This block steers a single agent through a square grid maze of 128 by 128 cells held in an external byte-wide memory. It keeps the agent's column and row coordinates and its compass heading. Each time the agent steps into a cell, the block reads that cell's code byte, writes a zero "crumb eaten" marker into the upper half of the memory, and then picks moves by following the wall on its right hand. It stops for good when the cell byte carries the exit bit. It also stops, with an error flag, when the byte says the agent is inside solid wall.

The memory interface is one address bus, one write-data bus, one write strobe and one read-data bus. Reads complete in the same cycle: the byte for the address on the bus is expected on `mem_rdata` before the next rising edge. The lower memory half holds the maze and the upper half holds the crumbs, and the top address bit selects between them.

The controller is a one-hot state machine with six states. FETCH drives the read address and latches the cell byte, then goes to MARK. MARK writes the crumb, then goes to DECIDE. DECIDE goes to FAULT on a fault code and to DONE on the exit code. Otherwise it does one of three things. It may advance and go back to FETCH. It may turn right and go to STEP. It may turn left and stay in DECIDE. STEP advances and returns to FETCH. DONE and FAULT hold until reset.

Top module: `maze_walker`

## Requirements
- R1: While reset is held and when it is released, the agent is at x=1, y=1 with heading east, `done` and `error` are low, `mem_we` is low and `mem_addr` is 15'h0081.
- R2: A cell byte is read at address {1'b0, x, y}, with x in bits 13:7 and y in bits 6:0. This is the address driven in the cycle just before that cell's crumb write.
- R3: Each cell entry produces exactly one write cycle, with `mem_we` high, `mem_wdata` = 8'h00 and address {1'b1, x, y}. It comes in the cycle after the read of that cell.
- R4: Cell byte bits: bit1 north wall, bit2 west wall, bit3 south wall, bit4 east wall, bit0 no wall, bit5 exit, bit6 inside wall. Several wall bits may be set together and each is honoured.
- R5: `heading` is one-hot, with bit0 north, bit1 east, bit2 south and bit3 west. Turning right goes N to E to S to W to N, and turning left goes the other way.
- R6: Moving forward changes exactly one coordinate by one. North decrements y, south increments y, east increments x and west decrements x.
- R7: Move choice follows the right-hand wall. If the right side is open, turn right and then step forward. Otherwise, if the front is open, step forward. Otherwise turn left and decide again on the same latched byte, without a new read.
- R8: On a byte with bit5 set, `done` rises two cycles after that cell's crumb write and stays high. After that there are no further writes, and position and heading stay frozen.
- R9: A byte with bit6 set, or a byte of all zeros, raises `error` two cycles after the crumb write and halts the agent as in R8. This check wins over the exit bit.
- R10: Crumb writes are 3 cycles apart after a plain forward step and 4 cycles apart after a right turn plus step, plus 1 cycle for each left turn. The first write comes one cycle after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 15 | Memory address {half, x, y} |
| mem_wdata | output | 8 | Write data (always zero crumb marker) |
| mem_we | output | 1 | Write strobe for the crumb mark |
| mem_rdata | input | 8 | Cell byte returned for `mem_addr` in the same cycle |
| pos_x | output | 7 | Current column |
| pos_y | output | 7 | Current row |
| heading | output | 4 | One-hot heading (bit0 N, bit1 E, bit2 S, bit3 W) |
| done | output | 1 | Exit reached, held |
| error | output | 1 | Fault code read, held |

## Verification
The hardest situations to reach are cells where the agent has to turn left once or twice before it can leave, and the case where one cell carries both the exit and the fault code. The stimulus sweeps rectangular rooms of every size from 1x1 to 4x4. These include one-cell-wide corridors, whose dead ends force double left turns. The exit and a fault cell are placed at each corner of the walked perimeter, and in a one-row room the fault and exit land on the same cell. A step-level model in the bench predicts every crumb write, its gap in cycles, the heading at entry and the way the walk ends.

// File: rtl/maze_walker_pkg.sv
package maze_walker_pkg;

    // Heading bit positions in the one-hot heading vector
    localparam int HD_N = 0;
    localparam int HD_E = 1;
    localparam int HD_S = 2;
    localparam int HD_W = 3;
    localparam int HD_COUNT = 4;

    // Cell code bit positions
    localparam int CB_OPEN  = 0;
    localparam int CB_NORTH = 1;
    localparam int CB_WEST  = 2;
    localparam int CB_SOUTH = 3;
    localparam int CB_EAST  = 4;
    localparam int CB_EXIT  = 5;
    localparam int CB_SOLID = 6;
    localparam int CB_USED  = 7;

    typedef enum logic [1:0] {
        MV_FWD   = 2'd0,
        MV_RIGHT = 2'd1,
        MV_LEFT  = 2'd2
    } move_e;

    typedef enum logic [5:0] {
        ST_FETCH  = 6'b000001,
        ST_MARK   = 6'b000010,
        ST_DECIDE = 6'b000100,
        ST_STEP   = 6'b001000,
        ST_DONE   = 6'b010000,
        ST_FAULT  = 6'b100000
    } walk_state_e;

    // Which cell-code bit holds the wall facing a given heading index
    function automatic int wall_bit(input int dir);
        case (dir)
            HD_N:    return CB_NORTH;
            HD_E:    return CB_EAST;
            HD_S:    return CB_SOUTH;
            default: return CB_WEST;
        endcase
    endfunction

    function automatic logic [HD_COUNT-1:0] rot_right(input logic [HD_COUNT-1:0] h);
        return {h[HD_COUNT-2:0], h[HD_COUNT-1]};
    endfunction

    function automatic logic [HD_COUNT-1:0] rot_left(input logic [HD_COUNT-1:0] h);
        return {h[0], h[HD_COUNT-1:1]};
    endfunction

endpackage

// File: rtl/mw_heading.sv
module mw_heading
    import maze_walker_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                turn_r_i,
    input  logic                turn_l_i,
    output logic [HD_COUNT-1:0] heading_o
);

    localparam logic [HD_COUNT-1:0] HEADING_RST = HD_COUNT'(1) << HD_E;

    logic [HD_COUNT-1:0] heading_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            heading_q <= HEADING_RST;
        end else if (turn_r_i) begin
            heading_q <= rot_right(heading_q);
        end else if (turn_l_i) begin
            heading_q <= rot_left(heading_q);
        end
    end

    assign heading_o = heading_q;

    // R5: heading stays one-hot
    a_r5_heading_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(heading_q) == 1);

    // R5: a right turn moves to the next compass point clockwise
    a_r5_right_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_r_i && heading_q[HD_N]) |=> heading_q[HD_E]);

endmodule

// File: rtl/mw_position.sv
module mw_position
    import maze_walker_pkg::*;
#(
    parameter int COORD_W = 7,
    parameter int START_X = 1,
    parameter int START_Y = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance_i,
    input  logic [HD_COUNT-1:0] heading_i,
    output logic [COORD_W-1:0]  x_o,
    output logic [COORD_W-1:0]  y_o
);

    localparam logic [COORD_W-1:0] X_RST = COORD_W'(START_X);
    localparam logic [COORD_W-1:0] Y_RST = COORD_W'(START_Y);
    localparam logic [COORD_W-1:0] ONE   = COORD_W'(1);

    logic [COORD_W-1:0] x_q;
    logic [COORD_W-1:0] y_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= X_RST;
            y_q <= Y_RST;
        end else if (advance_i) begin
            if (heading_i[HD_N]) begin
                y_q <= y_q - ONE;
            end else if (heading_i[HD_S]) begin
                y_q <= y_q + ONE;
            end else if (heading_i[HD_E]) begin
                x_q <= x_q + ONE;
            end else begin
                x_q <= x_q - ONE;
            end
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

    // R6: an east step raises x by one and leaves y alone
    a_r6_east_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && heading_i[HD_E]) |=> (x_q == $past(x_q) + ONE) && $stable(y_q));

    // R6: a north step lowers y by one and leaves x alone
    a_r6_north_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && heading_i[HD_N]) |=> (y_q == $past(y_q) - ONE) && $stable(x_q));

endmodule

// File: rtl/mw_policy.sv
module mw_policy
    import maze_walker_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   cell_i,
    input  logic [HD_COUNT-1:0] heading_i,
    output move_e               move_o,
    output logic                exit_o,
    output logic                fault_o
);

    logic [HD_COUNT-1:0] wall_vec;
    logic [HD_COUNT-1:0] right_dir;
    logic                front_blocked;
    logic                right_blocked;

    // Map each heading index to its wall bit in the cell byte
    for (genvar d = 0; d < HD_COUNT; d++) begin : g_wall
        localparam int WB = wall_bit(d);
        assign wall_vec[d] = cell_i[WB];
    end

    always_comb begin
        right_dir     = rot_right(heading_i);
        front_blocked = |(wall_vec & heading_i);
        right_blocked = |(wall_vec & right_dir);
        fault_o       = cell_i[CB_SOLID] | ~(|cell_i);
        exit_o        = cell_i[CB_EXIT];
        if (!right_blocked) begin
            move_o = MV_RIGHT;
        end else if (!front_blocked) begin
            move_o = MV_FWD;
        end else begin
            move_o = MV_LEFT;
        end
    end

endmodule

// File: rtl/maze_walker.sv
module maze_walker
    import maze_walker_pkg::*;
#(
    parameter int COORD_W = 7,
    parameter int DATA_W  = 8,
    parameter int START_X = 1,
    parameter int START_Y = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [2*COORD_W:0]        mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic                      mem_we,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [COORD_W-1:0]        pos_x,
    output logic [COORD_W-1:0]        pos_y,
    output logic [HD_COUNT-1:0]       heading,
    output logic                      done,
    output logic                      error
);

    localparam int ADDR_W = 2 * COORD_W + 1;

    walk_state_e          state_q;
    walk_state_e          state_d;
    logic [DATA_W-1:0]    cell_q;
    logic                 advance;
    logic                 turn_r;
    logic                 turn_l;
    move_e                move;
    logic                 cell_exit;
    logic                 cell_fault;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Latched cell byte, captured during the read cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else if (state_q == ST_FETCH) begin
            cell_q <= mem_rdata;
        end
    end

    // Next-state and move strobes
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        turn_r  = 1'b0;
        turn_l  = 1'b0;
        unique case (state_q)
            ST_FETCH: state_d = ST_MARK;
            ST_MARK:  state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (cell_fault) begin
                    state_d = ST_FAULT;
                end else if (cell_exit) begin
                    state_d = ST_DONE;
                end else begin
                    unique case (move)
                        MV_FWD: begin
                            advance = 1'b1;
                            state_d = ST_FETCH;
                        end
                        MV_RIGHT: begin
                            turn_r  = 1'b1;
                            state_d = ST_STEP;
                        end
                        default: begin
                            turn_l  = 1'b1;
                            state_d = ST_DECIDE;
                        end
                    endcase
                end
            end
            ST_STEP: begin
                advance = 1'b1;
                state_d = ST_FETCH;
            end
            ST_DONE:  state_d = ST_DONE;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FETCH;
        endcase
    end

    // Outputs taken from the one-hot state bits
    always_comb begin
        mem_we    = state_q[1];
        done      = state_q[4];
        error     = state_q[5];
        mem_wdata = '0;
        mem_addr  = {state_q[1], pos_x, pos_y};
    end

    mw_policy #(
        .DATA_W (DATA_W)
    ) policy_i (
        .cell_i    (cell_q),
        .heading_i (heading),
        .move_o    (move),
        .exit_o    (cell_exit),
        .fault_o   (cell_fault)
    );

    mw_heading heading_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .turn_r_i  (turn_r),
        .turn_l_i  (turn_l),
        .heading_o (heading)
    );

    mw_position #(
        .COORD_W (COORD_W),
        .START_X (START_X),
        .START_Y (START_Y)
    ) position_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .heading_i (heading),
        .x_o       (pos_x),
        .y_o       (pos_y)
    );

    // R3: a crumb write targets the upper half with zero data
    a_r3_mark_target: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1] && (mem_wdata == '0)));

    // R2: a write is preceded by a read of the same cell in the lower half
    a_r2_read_before_mark: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!$past(mem_we) && ($past(mem_addr) == {1'b0, mem_addr[ADDR_W-2:0]})));

    // R8: once done, it stays, with no writes and a frozen agent
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !mem_we && $stable(pos_x) && $stable(pos_y) && $stable(heading)));

    // R9: the fault halt holds and never turns into done
    a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && !done && !mem_we));

    // R6: never both coordinates change at once
    a_r6_one_axis: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_x) |-> $stable(pos_y));

    // R7: a left turn re-decides on the same latched byte
    a_r7_left_rethinks: assert property (@(posedge clk) disable iff (!rst_n)
        turn_l |=> ((state_q == ST_DECIDE) && $stable(cell_q)));

endmodule

// File: tb/maze_walker_tb_top.sv
module maze_walker_tb_top;

    logic        clk;
    logic        rst_n;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [6:0]  pos_x;
    logic [6:0]  pos_y;
    logic [3:0]  heading;
    logic        done;
    logic        error;

    int checks = 0;
    int errors = 0;
    int total_cycles = 0;

    // Scenario: rectangular room with an exit cell and an optional fault cell
    int room_w = 1;
    int room_h = 1;
    int exit_x = 1;
    int exit_y = 1;
    int flt_on = 0;
    int flt_x  = 0;
    int flt_y  = 0;
    int flt_code = 8'h40;

    // Expected crumb writes from the step model
    int ex_x   [64];
    int ex_y   [64];
    int ex_h   [64];
    int ex_gap [64];
    int ex_n;
    int ex_fault;
    int ex_done;

    maze_walker dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .heading   (heading),
        .done      (done),
        .error     (error)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic int cell_at(input int x, input int y);
        int c;
        if (x < 1 || x > room_w || y < 1 || y > room_h) return 8'h40;
        c = 0;
        if (y == 1)      c = c | 8'h02;
        if (x == 1)      c = c | 8'h04;
        if (y == room_h) c = c | 8'h08;
        if (x == room_w) c = c | 8'h10;
        if (c == 0)      c = 8'h01;
        if (x == exit_x && y == exit_y) c = c | 8'h20;
        if (flt_on != 0 && x == flt_x && y == flt_y) c = flt_code | (c & 8'h20);
        return c;
    endfunction

    always_comb begin
        if (mem_addr[14]) mem_rdata = 8'h00;
        else mem_rdata = 8'(cell_at(int'(mem_addr[13:7]), int'(mem_addr[6:0])));
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Heading index 0 N, 1 E, 2 S, 3 W; wall bit per heading from R4
    function automatic bit blocked(input int c, input int h);
        case (h)
            0: return c[1];
            1: return c[4];
            2: return c[3];
            default: return c[2];
        endcase
    endfunction

    task automatic build_model();
        int x = 1, y = 1, h = 1, gap = 1;
        int halted = 0;
        ex_n = 0; ex_fault = 0; ex_done = 0;
        while (halted == 0 && ex_n < 64) begin
            int c = cell_at(x, y);
            ex_x[ex_n] = x; ex_y[ex_n] = y; ex_h[ex_n] = h; ex_gap[ex_n] = gap;
            ex_n++;
            if (c[6] || c == 0) begin
                ex_fault = 1; halted = 1;
            end else if (c[5]) begin
                ex_done = 1; halted = 1;
            end else begin
                int lefts = 0;
                bit moved = 0;
                gap = 3;
                while (!moved && lefts < 5) begin
                    if (!blocked(c, (h + 1) % 4)) begin
                        h = (h + 1) % 4; gap = gap + 1; moved = 1;
                    end else if (!blocked(c, h)) begin
                        moved = 1;
                    end else begin
                        h = (h + 3) % 4; gap = gap + 1; lefts++;
                    end
                end
                if (!moved) halted = 1;
                else begin
                    case (h)
                        0: y = y - 1;
                        1: x = x + 1;
                        2: y = y + 1;
                        default: x = x - 1;
                    endcase
                end
            end
        end
    endtask

    task automatic run_case();
        int cyc = 0, last = 0, idx = 0;
        logic [14:0] prev_addr;
        logic [6:0] hx, hy;
        logic [3:0] hh;
        build_model();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(pos_x == 7'd1 && pos_y == 7'd1, "R1", "reset position", int'({pos_x, pos_y}), 16'h0081);
        chk(heading == 4'b0010, "R1", "reset heading", int'(heading), 2);
        chk(!done && !error && !mem_we, "R1", "reset flags", int'({done, error, mem_we}), 0);
        chk(mem_addr == 15'h0081, "R1", "reset address", int'(mem_addr), 16'h0081);
        rst_n = 1'b1;
        prev_addr = mem_addr;
        while (!(idx == ex_n && cyc == last + 2) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (mem_we) begin
                if (idx < ex_n) begin
                    logic [14:0] wa = {1'b1, 7'(ex_x[idx]), 7'(ex_y[idx])};
                    logic [14:0] ra = {1'b0, 7'(ex_x[idx]), 7'(ex_y[idx])};
                    chk(mem_addr == wa, "R3", "crumb address", int'(mem_addr), int'(wa));
                    chk(mem_wdata == 8'h00, "R3", "crumb data", int'(mem_wdata), 0);
                    chk(prev_addr == ra, "R2", "read address before mark", int'(prev_addr), int'(ra));
                    chk(pos_x == 7'(ex_x[idx]) && pos_y == 7'(ex_y[idx]), "R6",
                        "position at entry", int'({pos_x, pos_y}), int'({7'(ex_x[idx]), 7'(ex_y[idx])}));
                    chk(heading == 4'(1 << ex_h[idx]), "R5", "heading at entry",
                        int'(heading), 1 << ex_h[idx]);
                    chk(cyc - last == ex_gap[idx], "R10", "cycles between marks (R7 moves)",
                        cyc - last, ex_gap[idx]);
                end else begin
                    chk(1'b0, "R8", "unexpected extra crumb write", idx, ex_n);
                end
                last = cyc;
                idx++;
            end
            prev_addr = mem_addr;
        end
        chk(idx == ex_n, "R3", "crumb write count", idx, ex_n);
        chk(done == ex_done[0], "R8", "done after final cell", int'(done), ex_done);
        chk(error == ex_fault[0], "R9", "error after final cell", int'(error), ex_fault);
        hx = pos_x; hy = pos_y; hh = heading;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!mem_we && pos_x == hx && pos_y == hy && heading == hh, "R8",
                "halted agent frozen", int'({mem_we, pos_x, pos_y}), int'({1'b0, hx, hy}));
            chk(done == ex_done[0] && error == ex_fault[0], "R9", "halt flags held",
                int'({done, error}), int'({ex_done[0], ex_fault[0]}));
        end
    endtask

    always @(posedge clk) begin
        total_cycles++;
        if (total_cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", total_cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        for (int w = 1; w <= 4; w++) begin
            for (int h = 1; h <= 4; h++) begin
                for (int v = 0; v < 6; v++) begin
                    room_w = w; room_h = h; flt_on = 0;
                    case (v)
                        0: begin exit_x = 1; exit_y = 1; end
                        1: begin exit_x = 1; exit_y = h; end
                        2: begin exit_x = w; exit_y = h; end
                        3: begin exit_x = w; exit_y = 1; end
                        4: begin exit_x = w; exit_y = 1; flt_on = 1; flt_x = w; flt_y = h; flt_code = 8'h40; end
                        default: begin exit_x = w; exit_y = 1; flt_on = 1; flt_x = w; flt_y = h; flt_code = 8'h00; end
                    endcase
                    if (!(w == 1 && h == 1 && v != 0 && v < 4)) run_case();
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule